// File: doc/BRIEF.md
# Programmable Display-Enable Generator with Embedded Timing Codes

This block rebuilds the active-video window of an incoming raster from the pixel clock, the horizontal and vertical sync pulses, and a set of static timing values. It counts pixels from each horizontal sync leading edge and lines from each vertical sync leading edge. From those counts it forms a display-enable (DE) window that begins a set distance after each sync edge and covers a set width and height. When the generated window is selected, it replaces the DE that arrives with the video.

It can also turn its 8-bit output into a stream with embedded timing codes. A four-byte end-of-active-video code follows each line's active pixels and a start-of-active-video code precedes them. Between the codes, blanking levels are inserted. For interlaced sources, a field flag comes from where the vertical sync edge falls within the line. Field 1 shifts the vertical window by a programmable number of lines. All configuration is captured only at a vertical sync leading edge, so a frame is never built from a mix of old and new settings.

Top module: `vid_window_gen`

## Requirements
- R1: A clock edge with `rst_n` low clears `de_out`, `vid_out` and `field_out` to 0. The captured settings then take their defaults: vertical delay 24, horizontal delay 0x104, width 0x500, height 0x2D0, field offset 0, both enables 0. Until the first vertical sync leading edge, `de_out` and `vid_out` therefore repeat `de_in` and `pix_in` one cycle later.
- R2: While the captured window-select enable is 0, `de_out` equals `de_in` delayed by one clock.
- R3: The configuration inputs are captured only at the clock edge where `vsync_in` is first sampled high. A change at any other time has no effect on the outputs until that edge.
- R4: The pixel position is 0 in the cycle after the edge where `hsync_in` is first sampled high, and it counts up by one per clock, saturating. On an active line with the window selected, `de_out` is 1 one cycle after positions `hdelay` through `hdelay + width - 1`.
- R5: The line number is 0 after a vertical sync leading edge and increases at each horizontal sync leading edge. In field 0, the active lines are `vdelay` through `vdelay + height - 1`. On any other line, `de_out` stays 0 while the window is selected.
- R6: At a vertical sync leading edge, `field_out` becomes 1 if the pixel position is at least the captured `hdelay`, and 0 otherwise. It holds between such edges.
- R7: In field 1, the active lines are shifted later by the captured field offset.
- R8: With codes enabled, pixel positions `hdelay+width` through `hdelay+width+3` carry 0xFF, 0x00, 0x00, XY with H=1. When `hdelay >= 4`, positions `hdelay-4` through `hdelay-1` carry the same sequence with H=0. These codes appear on every line.
- R9: The XY byte is, from bit 7 down to bit 0: 1, F, V, H, V^H, F^H, F^V, F^V^H. F is the field flag and V is 1 on lines outside the active lines.
- R10: With codes enabled, positions inside the active window pass `pix_in`. Every other position carries 0x80 at even pixel positions and 0x10 at odd ones.
- R11: With codes disabled, `vid_out` equals `pix_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| de_in | input | 1 | Incoming display enable |
| pix_in | input | 8 | Incoming pixel data |
| cfg_codes_en | input | 1 | Embedded timing code enable |
| cfg_force_de | input | 1 | Select generated window for `de_out` |
| cfg_field_ofs | input | 3 | Field 1 vertical offset in lines |
| cfg_vdelay | input | 6 | Lines from vertical sync edge to first active line |
| cfg_hdelay | input | 10 | Pixels from horizontal sync edge to first active pixel |
| cfg_width | input | 12 | Active pixels per line |
| cfg_height | input | 12 | Active lines per field |
| de_out | output | 1 | Display enable, registered |
| field_out | output | 1 | Field flag |
| vid_out | output | 8 | Video stream, registered |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any property is used. They also assume that the sync inputs are clean levels sampled on `clk`, so the edge detectors see each leading edge once. The stimulus meets both assumptions: it holds reset across two edges, drives each sync high for whole cycles from tasks on the falling clock edge, and starts every vertical sync at a chosen pixel position well away from the horizontal sync pulse. It also keeps the programmed horizontal delay at least four pixels and lines long enough to hold both codes.

// File: rtl/vwg_pkg.sv
// Shared definitions for the display-enable generator: output slot
// kinds, code and blanking byte values, and the timing-code encoder.
package vwg_pkg;

    typedef enum logic [1:0] {
        SLOT_BLANK = 2'd0,
        SLOT_PIX   = 2'd1,
        SLOT_EAV   = 2'd2,
        SLOT_SAV   = 2'd3
    } slot_e;

    localparam logic [7:0] CODE_LEAD  = 8'hFF;
    localparam logic [7:0] CODE_ZERO  = 8'h00;
    localparam logic [7:0] BLANK_EVEN = 8'h80;
    localparam logic [7:0] BLANK_ODD  = 8'h10;

    // Status word: fixed 1, flags, then four protection bits
    function automatic logic [7:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Byte idx of a four-byte timing code
    function automatic logic [7:0] code_byte(input logic [1:0] idx, input logic f,
                                             input logic v, input logic h);
        case (idx)
            2'd0:    return CODE_LEAD;
            2'd3:    return xy_word(f, v, h);
            default: return CODE_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/vwg_cfg_latch.sv
// Configuration capture. Holds a private copy of every timing setting
// and reloads it only when load is high (a vertical sync leading edge).
// Assumes the cfg inputs are static or change well away from that edge.
module vwg_cfg_latch #(
    parameter int HD_W  = 10,
    parameter int VD_W  = 6,
    parameter int LW_W  = 12,
    parameter int LH_W  = 12,
    parameter int OFS_W = 3,
    parameter logic [HD_W-1:0] HD_INIT = HD_W'('h104),
    parameter logic [VD_W-1:0] VD_INIT = VD_W'(24),
    parameter logic [LW_W-1:0] LW_INIT = LW_W'('h500),
    parameter logic [LH_W-1:0] LH_INIT = LH_W'('h2D0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             codes_en,
    input  logic             force_de,
    input  logic [OFS_W-1:0] field_ofs,
    input  logic [VD_W-1:0]  vdelay,
    input  logic [HD_W-1:0]  hdelay,
    input  logic [LW_W-1:0]  width,
    input  logic [LH_W-1:0]  height,
    output logic             codes_q,
    output logic             force_q,
    output logic [OFS_W-1:0] ofs_q,
    output logic [VD_W-1:0]  vd_q,
    output logic [HD_W-1:0]  hd_q,
    output logic [LW_W-1:0]  w_q,
    output logic [LH_W-1:0]  ht_q
);

    // Load defaults on reset, new settings on a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codes_q <= 1'b0;
            force_q <= 1'b0;
            ofs_q   <= '0;
            vd_q    <= VD_INIT;
            hd_q    <= HD_INIT;
            w_q     <= LW_INIT;
            ht_q    <= LH_INIT;
        end else if (load) begin
            codes_q <= codes_en;
            force_q <= force_de;
            ofs_q   <= field_ofs;
            vd_q    <= vdelay;
            hd_q    <= hdelay;
            w_q     <= width;
            ht_q    <= height;
        end
    end

endmodule

// File: rtl/vwg_timing.sv
// Raster timing: sync edge detection, saturating pixel and line counters,
// field detection and the active window. Also classifies the current pixel
// position as code, active or blanking. All outputs describe the position
// before the next clock edge. Assumes active-high syncs synchronous to clk.
module vwg_timing
    import vwg_pkg::*;
#(
    parameter int HD_W  = 10,
    parameter int VD_W  = 6,
    parameter int LW_W  = 12,
    parameter int LH_W  = 12,
    parameter int OFS_W = 3,
    parameter int CW    = 13,
    parameter int VCW   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [HD_W-1:0]  hd,
    input  logic [LW_W-1:0]  w,
    input  logic [VD_W-1:0]  vd,
    input  logic [LH_W-1:0]  ht,
    input  logic [OFS_W-1:0] ofs,
    output logic             hs_q,
    output logic             vs_q,
    output logic             vs_rise,
    output logic [CW-1:0]    hcnt,
    output logic [VCW-1:0]   vcnt,
    output logic             field,
    output logic             gen_de,
    output logic             v_blank,
    output logic             pos_odd,
    output slot_e            slot,
    output logic [1:0]       idx
);

    logic           hs_rise;
    logic           v_act;
    logic           h_act;
    logic [CW-1:0]  h_start;
    logic [CW-1:0]  h_end;
    logic [VCW-1:0] v_first;
    logic [VCW-1:0] v_last;

    assign hs_rise = hsync_in & ~hs_q;
    assign vs_rise = vsync_in & ~vs_q;

    // Previous sync levels for leading-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync_in;
            vs_q <= vsync_in;
        end
    end

    // Pixel position within the line, restarted by horizontal sync
    always_ff @(posedge clk) begin
        if (!rst_n)               hcnt <= '0;
        else if (hs_rise)         hcnt <= '0;
        else if (hcnt != '1)      hcnt <= hcnt + CW'(1);
    end

    // Line number within the field, restarted by vertical sync
    always_ff @(posedge clk) begin
        if (!rst_n)                        vcnt <= '0;
        else if (vs_rise)                  vcnt <= '0;
        else if (hs_rise && vcnt != '1)    vcnt <= vcnt + VCW'(1);
    end

    // Field flag from the position of the vertical sync edge in the line
    always_ff @(posedge clk) begin
        if (!rst_n)        field <= 1'b0;
        else if (vs_rise)  field <= (hcnt >= CW'(hd));
    end

    // Active window bounds
    always_comb begin
        h_start = CW'(hd);
        h_end   = CW'(hd) + CW'(w);
        v_first = VCW'(vd) + (field ? VCW'(ofs) : VCW'(0));
        v_last  = v_first + VCW'(ht);
        h_act   = (hcnt >= h_start) && (hcnt < h_end);
        v_act   = (vcnt >= v_first) && (vcnt < v_last);
    end

    assign gen_de  = h_act & v_act;
    assign v_blank = ~v_act;
    assign pos_odd = hcnt[0];

    // Classify the position: end code, start code, active pixel or blanking
    always_comb begin
        slot = SLOT_BLANK;
        idx  = 2'd0;
        if ((hcnt >= h_end) && (hcnt < h_end + CW'(4))) begin
            slot = SLOT_EAV;
            idx  = 2'(hcnt - h_end);
        end else if ((h_start >= CW'(4)) && (hcnt >= h_start - CW'(4)) && (hcnt < h_start)) begin
            slot = SLOT_SAV;
            idx  = 2'(hcnt - (h_start - CW'(4)));
        end else if (gen_de) begin
            slot = SLOT_PIX;
        end
    end

endmodule

// File: rtl/vwg_stream.sv
// Output stage: one register for the display enable and the 8-bit stream.
// Selects incoming or generated DE, and either passes pixels through or
// builds the code-bearing stream from the slot classification.
module vwg_stream
    import vwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_q,
    input  logic       codes_q,
    input  logic       de_in,
    input  logic [7:0] pix_in,
    input  logic       gen_de,
    input  slot_e      slot,
    input  logic [1:0] idx,
    input  logic       field,
    input  logic       v_blank,
    input  logic       pos_odd,
    output logic       de_out,
    output logic [7:0] vid_out
);

    logic [7:0] vid_nxt;

    // Next stream byte for the current position
    always_comb begin
        if (!codes_q) begin
            vid_nxt = pix_in;
        end else begin
            case (slot)
                SLOT_PIX: vid_nxt = pix_in;
                SLOT_EAV: vid_nxt = code_byte(idx, field, v_blank, 1'b1);
                SLOT_SAV: vid_nxt = code_byte(idx, field, v_blank, 1'b0);
                default:  vid_nxt = pos_odd ? BLANK_ODD : BLANK_EVEN;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_out  <= 1'b0;
            vid_out <= '0;
        end else begin
            de_out  <= force_q ? gen_de : de_in;
            vid_out <= vid_nxt;
        end
    end

endmodule

// File: rtl/vid_window_gen.sv
// Programmable display-enable generator with optional embedded timing codes.
// Captures settings at each vertical sync leading edge, counts the raster
// from sync leading edges and drives a registered DE and 8-bit stream.
// Assumes active-high syncs synchronous to clk and a horizontal delay of at
// least four pixels when start codes are wanted.
module vid_window_gen
    import vwg_pkg::*;
#(
    parameter int HD_W  = 10,
    parameter int VD_W  = 6,
    parameter int LW_W  = 12,
    parameter int LH_W  = 12,
    parameter int OFS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             de_in,
    input  logic [7:0]       pix_in,
    input  logic             cfg_codes_en,
    input  logic             cfg_force_de,
    input  logic [OFS_W-1:0] cfg_field_ofs,
    input  logic [VD_W-1:0]  cfg_vdelay,
    input  logic [HD_W-1:0]  cfg_hdelay,
    input  logic [LW_W-1:0]  cfg_width,
    input  logic [LH_W-1:0]  cfg_height,
    output logic             de_out,
    output logic             field_out,
    output logic [7:0]       vid_out
);

    localparam int CW  = ((HD_W > LW_W) ? HD_W : LW_W) + 1;
    localparam int VCW = ((VD_W > LH_W) ? VD_W : LH_W) + 1;

    logic             codes_q;
    logic             force_q;
    logic [OFS_W-1:0] ofs_q;
    logic [VD_W-1:0]  vd_q;
    logic [HD_W-1:0]  hd_q;
    logic [LW_W-1:0]  w_q;
    logic [LH_W-1:0]  ht_q;
    logic             hs_q;
    logic             vs_q;
    logic             vs_rise;
    logic [CW-1:0]    hcnt;
    logic [VCW-1:0]   vcnt;
    logic             field;
    logic             gen_de;
    logic             v_blank;
    logic             pos_odd;
    slot_e            slot;
    logic [1:0]       idx;

    vwg_cfg_latch #(
        .HD_W(HD_W), .VD_W(VD_W), .LW_W(LW_W), .LH_W(LH_W), .OFS_W(OFS_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(vs_rise),
        .codes_en(cfg_codes_en), .force_de(cfg_force_de), .field_ofs(cfg_field_ofs),
        .vdelay(cfg_vdelay), .hdelay(cfg_hdelay), .width(cfg_width), .height(cfg_height),
        .codes_q(codes_q), .force_q(force_q), .ofs_q(ofs_q), .vd_q(vd_q),
        .hd_q(hd_q), .w_q(w_q), .ht_q(ht_q)
    );

    vwg_timing #(
        .HD_W(HD_W), .VD_W(VD_W), .LW_W(LW_W), .LH_W(LH_W), .OFS_W(OFS_W),
        .CW(CW), .VCW(VCW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hd(hd_q), .w(w_q), .vd(vd_q), .ht(ht_q), .ofs(ofs_q),
        .hs_q(hs_q), .vs_q(vs_q), .vs_rise(vs_rise), .hcnt(hcnt), .vcnt(vcnt),
        .field(field), .gen_de(gen_de), .v_blank(v_blank), .pos_odd(pos_odd),
        .slot(slot), .idx(idx)
    );

    vwg_stream u_stream (
        .clk(clk), .rst_n(rst_n), .force_q(force_q), .codes_q(codes_q),
        .de_in(de_in), .pix_in(pix_in), .gen_de(gen_de), .slot(slot), .idx(idx),
        .field(field), .v_blank(v_blank), .pos_odd(pos_odd),
        .de_out(de_out), .vid_out(vid_out)
    );

    assign field_out = field;

endmodule

// File: rtl/vwg_checker.sv
// Temporal checks for vid_window_gen, attached with bind. Assumes reset is
// held for at least one edge and syncs are sampled levels on clk.
module vwg_checker #(
    parameter int CW  = 13,
    parameter int VCW = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hsync_in,
    input logic           vsync_in,
    input logic           de_in,
    input logic [7:0]     pix_in,
    input logic           de_out,
    input logic           field_out,
    input logic [7:0]     vid_out,
    input logic           force_q,
    input logic           codes_q,
    input logic           hs_q,
    input logic           vs_q,
    input logic [CW-1:0]  hcnt,
    input logic [VCW-1:0] vcnt
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!de_out && !field_out && vid_out == 8'h00));

    assert_de_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !force_q |=> (de_out == $past(de_in)));

    assert_hpos_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_in && !hs_q) |=> (hcnt == '0));

    assert_line_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_in && !vs_q) |=> (vcnt == '0));

    assert_field_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsync_in && !vs_q) |=> $stable(field_out));

    assert_pix_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !codes_q |=> (vid_out == $past(pix_in)));

endmodule

bind vid_window_gen vwg_checker #(.CW(CW), .VCW(VCW)) u_vwg_checker (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .de_in(de_in), .pix_in(pix_in), .de_out(de_out), .field_out(field_out),
    .vid_out(vid_out), .force_q(force_q), .codes_q(codes_q),
    .hs_q(hs_q), .vs_q(vs_q), .hcnt(hcnt), .vcnt(vcnt)
);

// File: tb/test_vid_window_gen.sv
`timescale 1ns/1ps
module test_vid_window_gen;

    localparam int LINE = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        de_in = 1'b0;
    logic [7:0]  pix_in = 8'h00;
    logic        c_codes = 1'b0;
    logic        c_force = 1'b0;
    logic [2:0]  c_ofs = 3'd0;
    logic [5:0]  c_vd = 6'd0;
    logic [9:0]  c_hd = 10'd0;
    logic [11:0] c_w = 12'd0;
    logic [11:0] c_ht = 12'd0;
    logic        de_out;
    logic        field_out;
    logic [7:0]  vid_out;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference state derived from the requirements
    int m_hd, m_w, m_vd, m_ht, m_ofs;
    bit m_force, m_codes, m_field, m_hs, m_vs;
    int mh, mv;

    always #2.5 clk = ~clk;

    vid_window_gen i_vid_window_gen (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .de_in(de_in), .pix_in(pix_in), .cfg_codes_en(c_codes), .cfg_force_de(c_force),
        .cfg_field_ofs(c_ofs), .cfg_vdelay(c_vd), .cfg_hdelay(c_hd), .cfg_width(c_w),
        .cfg_height(c_ht), .de_out(de_out), .field_out(field_out), .vid_out(vid_out)
    );

    task automatic check(input bit ok, input string tag, input string req,
                         input string what, input int got, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s %s: actual=%0h expected=%0h", req, tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] ref_code(input int k, input bit f, input bit v, input bit h);
        if (k == 0) return 8'hFF;
        if (k == 3) return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        return 8'h00;
    endfunction

    // One clock: drive at the falling edge, predict, check at the next falling edge
    task automatic step(input bit hs, input bit vs, input bit de, input logic [7:0] pix,
                        input string tag);
        bit hr, vr, vact, gen, e_de;
        logic [7:0] e_vid;
        int vfirst, hend;
        string dtag, vtag;
        hsync_in = hs; vsync_in = vs; de_in = de; pix_in = pix;
        hr = hs && !m_hs;
        vr = vs && !m_vs;
        vfirst = m_vd + (m_field ? m_ofs : 0);
        vact = (mv >= vfirst) && (mv < vfirst + m_ht);
        hend = m_hd + m_w;
        gen = vact && (mh >= m_hd) && (mh < hend);
        e_de = m_force ? gen : de;
        dtag = m_force ? (m_field ? "R7" : (vact ? "R4" : "R5")) : "R2";
        if (!m_codes) begin
            e_vid = pix; vtag = "R11";
        end else if (mh >= hend && mh < hend + 4) begin
            e_vid = ref_code(mh - hend, m_field, !vact, 1'b1);
            vtag = (mh - hend == 3) ? "R9" : "R8";
        end else if (m_hd >= 4 && mh >= m_hd - 4 && mh < m_hd) begin
            e_vid = ref_code(mh - (m_hd - 4), m_field, !vact, 1'b0);
            vtag = (mh - (m_hd - 4) == 3) ? "R9" : "R8";
        end else if (gen) begin
            e_vid = pix; vtag = "R10";
        end else begin
            e_vid = (mh % 2 == 1) ? 8'h10 : 8'h80; vtag = "R10";
        end
        if (vr) begin
            m_field = (mh >= m_hd);
            m_hd = c_hd; m_w = c_w; m_vd = c_vd; m_ht = c_ht; m_ofs = c_ofs;
            m_force = c_force; m_codes = c_codes;
            mv = 0;
        end else if (hr && mv < 8191) begin
            mv = mv + 1;
        end
        if (hr) mh = 0;
        else if (mh < 8191) mh = mh + 1;
        m_hs = hs; m_vs = vs;
        @(negedge clk);
        check(de_out === e_de, tag, dtag, "de_out", int'(de_out), int'(e_de));
        check(vid_out === e_vid, tag, vtag, "vid_out", int'(vid_out), int'(e_vid));
        check(field_out === m_field, tag, "R6", "field_out", int'(field_out), int'(m_field));
    endtask

    // Frame of n lines; vertical sync rises at pixel vs_pos of line 0
    task automatic run_frame(input int n, input int vs_pos, input string tag);
        for (int ln = 0; ln < n; ln++) begin
            for (int p = 0; p < LINE; p++) begin
                bit vs;
                vs = (ln == 0 && p >= vs_pos) || (ln == 1 && p < vs_pos);
                step(p < 2, vs, p[0], 8'((ln * 16 + p) ^ 8'h5A), tag);
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        hsync_in = 1'b0; vsync_in = 1'b0; de_in = 1'b1; pix_in = 8'hC3;
        @(negedge clk); @(negedge clk);
        check(de_out === 1'b0, "reset", "R1", "de_out", int'(de_out), 0);
        check(vid_out === 8'h00, "reset", "R1", "vid_out", int'(vid_out), 0);
        check(field_out === 1'b0, "reset", "R1", "field_out", int'(field_out), 0);
        m_hd = 'h104; m_w = 'h500; m_vd = 24; m_ht = 'h2D0; m_ofs = 0;
        m_force = 0; m_codes = 0; m_field = 0; m_hs = 0; m_vs = 0; mh = 0; mv = 0;
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, i[0], 8'(8'h30 + i), "R1");
    endtask

    task automatic t_passthru;
        // Defaults captured: DE and pixels follow the inputs (R2, R11)
        for (int i = 0; i < 2 * LINE; i++)
            step(i % LINE < 2, 1'b0, i[1], 8'(i * 37), "R2");
    endtask

    task automatic t_program_pending;
        // New settings not yet captured: still pass-through (R3)
        c_hd = 10'd6; c_w = 12'd8; c_vd = 6'd2; c_ht = 12'd3; c_ofs = 3'd2;
        c_force = 1'b1; c_codes = 1'b0;
        for (int i = 0; i < LINE; i++)
            step(i < 2, 1'b0, ~i[0], 8'(i * 11), "R3");
    endtask

    task automatic t_window;
        run_frame(8, 3, "R4");
        run_frame(8, 3, "R5");
    endtask

    task automatic t_codes;
        c_codes = 1'b1;
        run_frame(8, 3, "R8");
        run_frame(8, 3, "R10");
    endtask

    task automatic t_field;
        run_frame(10, 12, "R7");
        run_frame(10, 3, "R6");
    endtask

    task automatic t_cfg_hold;
        // Change width mid-frame; takes effect only at the next vertical sync
        for (int ln = 0; ln < 8; ln++) begin
            for (int p = 0; p < LINE; p++) begin
                bit vs;
                if (ln == 2 && p == 10) begin c_w = 12'd4; c_codes = 1'b0; end
                vs = (ln == 0 && p >= 3) || (ln == 1 && p < 3);
                step(p < 2, vs, p[0], 8'(ln * 7 + p), "R3");
            end
        end
        run_frame(8, 3, "R3");
    endtask

    initial begin
        t_reset();
        t_passthru();
        t_program_pending();
        t_window();
        t_codes();
        t_field();
        t_cfg_hold();
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL all-requirements watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule